// File: doc/BRIEF.md
# Channel-Status Bit Register File

This block keeps the 32 channel-status configuration bits of a digital audio interface and gives a host one-bit-at-a-time access to them over a small byte-wide register bus. There are two registers. The control/status register is at address 0. The data register is at address 1. A write to the control register chooses how the next data-register accesses behave. In write mode, a data write stores one bit. In read mode, a data write only selects a bit, and a data read then returns that bit.

A read of the control register reports the receiver side. It shows whether a clock is present, a two-bit sample-rate code and whether data is present. These status inputs come from the surrounding logic. The stored bits are also available in parallel on `cs_bits_o` for a downstream serialiser. Bit 0, the professional/consumer flag, has its own output.

Top module: `csb_regfile`

## Requirements
- R1: Synchronous reset clears all 32 stored bits and selects write mode. The latched index resets to 0.
- R2: A control-register write (address 0) sets the access mode from data bit 0: 1 = read mode, 0 = write mode. The mode holds until the next control write.
- R3: In write mode, a data-register write (address 1) stores data bit 7 into the stored bit whose index is data bits [4:0]. No other stored bit changes.
- R4: Data bits 6:5 of a data-register write take no part in the index.
- R5: Every data-register write latches the index from bits [4:0]. In read mode this is the only effect, and the stored bits do not change.
- R6: A data-register read returns the stored bit at the latched index in bit 7. Bits 6:0 read 0.
- R7: A control-register read returns bit 0 = clock present, bits [2:1] = rate code, bit 3 = data present and bits [7:4] = 0. The rate codes are 01 = 32 kHz, 10 = 44.1 kHz, 11 = 48 kHz and 00 = unknown.
- R8: While clock present is low, the rate field reads 00 whatever the rate input is.
- R9: `pro_flag_o` follows stored bit 0, and `cs_bits_o` shows all stored bits, with index i on bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register select: 0 control/status, 1 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| clk_present_i | input | 1 | Receiver reports a clock |
| rate_code_i | input | 2 | Receiver sample-rate code |
| data_present_i | input | 1 | Receiver reports data |
| cs_bits_o | output | 32 | Stored channel-status bits |
| pro_flag_o | output | 1 | Professional/consumer flag (stored bit 0) |

## Verification
The bench writes indices with bits 6:5 set. A design that kept those bits in the index would write the wrong bit or no bit. It issues data writes with bit 7 set while in read mode. A design that stored on every data write would corrupt bit 30, and the later parallel-output check would catch it. It also reads the rate field with the clock absent, and it reads back bits 0 and 31 at the two ends of the index range. Finally, it resets the block in the middle of the run and writes without first writing the control register. A design that reset into read mode would leave the targeted bit clear.

// File: rtl/csb_pkg.sv
package csb_pkg;

    localparam int CS_BITS = 32;
    localparam int BYTE_W  = 8;
    localparam int VAL_POS = 7;
    localparam int FLD_W   = 5;

    typedef enum logic {
        MODE_WRITE = 1'b0,
        MODE_READ  = 1'b1
    } acc_mode_e;

    typedef enum logic [1:0] {
        RATE_NONE = 2'b00,
        RATE_32K  = 2'b01,
        RATE_44K1 = 2'b10,
        RATE_48K  = 2'b11
    } rate_e;

    typedef struct packed {
        logic  data_present;
        rate_e rate;
        logic  clk_present;
    } rx_status_t;

    function automatic logic [FLD_W-1:0] index_of(input logic [BYTE_W-1:0] d);
        return d[FLD_W-1:0];
    endfunction

    function automatic logic value_of(input logic [BYTE_W-1:0] d);
        return d[VAL_POS];
    endfunction

    function automatic acc_mode_e mode_of(input logic [BYTE_W-1:0] d);
        return acc_mode_e'(d[0]);
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input rx_status_t s);
        return {{(BYTE_W-$bits(rx_status_t)){1'b0}}, s};
    endfunction

endpackage

// File: rtl/csb_access_ctrl.sv
module csb_access_ctrl #(
    parameter int IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_wr,
    input  logic                 data_wr,
    input  csb_pkg::acc_mode_e   mode_in,
    input  logic [IDX_W-1:0]     idx_in,
    output csb_pkg::acc_mode_e   mode,
    output logic [IDX_W-1:0]     cur_idx,
    output logic                 store_we
);
    import csb_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_WRITE;
            cur_idx <= '0;
        end else begin
            if (ctrl_wr) mode    <= mode_in;
            if (data_wr) cur_idx <= idx_in;
        end
    end

    assign store_we = data_wr && (mode == MODE_WRITE);

endmodule

// File: rtl/csb_bit_store.sv
module csb_bit_store #(
    parameter int NUM_BITS = 32,
    parameter int IDX_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_val,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_bit,
    output logic [NUM_BITS-1:0]  bits_o
);

    for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                bits_o[i] <= 1'b0;
            else if (we && (wr_idx == IDX_W'(i)))
                bits_o[i] <= wr_val;
        end
    end

    always_comb begin
        rd_bit = 1'b0;
        for (int k = 0; k < NUM_BITS; k++)
            if (rd_idx == IDX_W'(k)) rd_bit = bits_o[k];
    end

endmodule

// File: rtl/csb_status_pack.sv
module csb_status_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk_present,
    input  logic [1:0]        rate_raw,
    input  logic              data_present,
    output logic [BYTE_W-1:0] status_byte
);
    import csb_pkg::*;

    rx_status_t st;

    always_comb begin
        st.clk_present  = clk_present;
        st.data_present = data_present;
        st.rate         = clk_present ? rate_e'(rate_raw) : RATE_NONE;
        status_byte     = pack_status(st);
    end

endmodule

// File: rtl/csb_regfile.sv
module csb_regfile #(
    parameter int NUM_BITS = csb_pkg::CS_BITS,
    parameter int BYTE_W   = csb_pkg::BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_addr,
    input  logic                reg_wr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    input  logic                clk_present_i,
    input  logic [1:0]          rate_code_i,
    input  logic                data_present_i,
    output logic [NUM_BITS-1:0] cs_bits_o,
    output logic                pro_flag_o
);
    import csb_pkg::*;

    localparam int IDX_W = $clog2(NUM_BITS);
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    acc_mode_e        acc_mode;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             store_we;
    logic             sel_bit;
    logic [BYTE_W-1:0] status_byte;

    assign wr_idx = IDX_W'(index_of(reg_wdata));

    csb_access_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (reg_wr && reg_addr == ADDR_CTRL),
        .data_wr  (reg_wr && reg_addr == ADDR_DATA),
        .mode_in  (mode_of(reg_wdata)),
        .idx_in   (wr_idx),
        .mode     (acc_mode),
        .cur_idx  (cur_idx),
        .store_we (store_we)
    );

    csb_bit_store #(.NUM_BITS(NUM_BITS), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (store_we),
        .wr_idx (wr_idx),
        .wr_val (value_of(reg_wdata)),
        .rd_idx (cur_idx),
        .rd_bit (sel_bit),
        .bits_o (cs_bits_o)
    );

    csb_status_pack #(.BYTE_W(BYTE_W)) u_status (
        .clk_present  (clk_present_i),
        .rate_raw     (rate_code_i),
        .data_present (data_present_i),
        .status_byte  (status_byte)
    );

    always_comb begin
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata = status_byte;
        end else begin
            reg_rdata          = '0;
            reg_rdata[VAL_POS] = sel_bit;
        end
    end

    assign pro_flag_o = cs_bits_o[0];

endmodule

// File: rtl/csb_regfile_chk.sv
module csb_regfile_chk #(
    parameter int NUM_BITS = 32,
    parameter int BYTE_W   = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_addr,
    input logic                reg_wr,
    input logic [BYTE_W-1:0]   reg_wdata,
    input logic [BYTE_W-1:0]   reg_rdata,
    input logic                clk_present_i,
    input logic [1:0]          rate_code_i,
    input logic                data_present_i,
    input logic [NUM_BITS-1:0] cs_bits_o,
    input logic                acc_mode
);
    import csb_pkg::*;

    // R1
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (cs_bits_o == '0 && acc_mode == 1'b0));

    // R2
    p_mode_follows_ctrl_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr) |=> (acc_mode == $past(reg_wdata[0])));

    // R3
    p_write_stores_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr && !acc_mode) |=>
        (cs_bits_o[$past(index_of(reg_wdata))] == $past(value_of(reg_wdata))));

    // R3: no data write means the store does not move
    p_idle_store_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr) |=> $stable(cs_bits_o));

    // R5
    p_read_mode_no_store_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr && acc_mode) |=> $stable(cs_bits_o));

    // R6
    p_data_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
        reg_addr |-> (reg_rdata[VAL_POS-1:0] == '0));

    // R7
    p_status_layout_r7: assert property (@(posedge clk) disable iff (rst)
        !reg_addr |-> (reg_rdata[0] == clk_present_i && reg_rdata[3] == data_present_i
                       && reg_rdata[BYTE_W-1:4] == '0));

    // R8
    p_rate_masked_r8: assert property (@(posedge clk) disable iff (rst)
        !reg_addr |-> (reg_rdata[2:1] == (clk_present_i ? rate_code_i : 2'b00)));

endmodule

bind csb_regfile csb_regfile_chk #(.NUM_BITS(NUM_BITS), .BYTE_W(BYTE_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .clk_present_i  (clk_present_i),
    .rate_code_i    (rate_code_i),
    .data_present_i (data_present_i),
    .cs_bits_o      (cs_bits_o),
    .acc_mode       (acc_mode)
);

// File: tb/csb_regfile_tb_top.sv
`timescale 1ns/1ps
module csb_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_addr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        clk_present_i = 1'b1;
    logic [1:0]  rate_code_i = 2'b10;
    logic        data_present_i = 1'b1;
    logic [31:0] cs_bits_o;
    logic        pro_flag_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    csb_regfile dut_i (
        .clk            (clk),
        .rst            (rst),
        .reg_addr       (reg_addr),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .clk_present_i  (clk_present_i),
        .rate_code_i    (rate_code_i),
        .data_present_i (data_present_i),
        .cs_bits_o      (cs_bits_o),
        .pro_flag_o     (pro_flag_o)
    );

    // vector: {is_read, addr, data, expected}
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h00, 8'h00},  // write mode
        {1'b0, 1'b1, 8'h85, 8'h00},  // bit5 = 1
        {1'b0, 1'b1, 8'h9F, 8'h00},  // bit31 = 1
        {1'b0, 1'b1, 8'h80, 8'h00},  // bit0 = 1
        {1'b0, 1'b1, 8'hAA, 8'h00},  // bit10 = 1, bit5 of data set (R4)
        {1'b0, 1'b0, 8'h01, 8'h00},  // read mode
        {1'b0, 1'b1, 8'h05, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'h80},  // bit5
        {1'b0, 1'b1, 8'h1F, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'h80},  // bit31
        {1'b0, 1'b1, 8'h0A, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'h80},  // bit10
        {1'b0, 1'b1, 8'h03, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'h00},  // bit3
        {1'b0, 1'b1, 8'h9E, 8'h00},  // read mode write: no store
        {1'b1, 1'b1, 8'h00, 8'h00},  // bit30 still 0
        {1'b1, 1'b0, 8'h00, 8'h0D},  // status: dp=1 rate=10 clk=1
        {1'b0, 1'b0, 8'h00, 8'h00},  // write mode
        {1'b0, 1'b1, 8'h05, 8'h00},  // clear bit5
        {1'b0, 1'b0, 8'h01, 8'h00},  // read mode
        {1'b0, 1'b1, 8'h05, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'h00}   // bit5 now 0
    };

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R9: reset state
        check("R1 cs_bits after reset", cs_bits_o, 32'h0);
        check("R9 pro flag after reset", {31'h0, pro_flag_o}, 32'h0);
        bus_read(1'b1, rd);
        check("R1/R6 data read at index 0 after reset", {24'h0, rd}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][17]) begin
                bus_read(VEC[v][16], rd);
                check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", v), {24'h0, rd},
                      {24'h0, VEC[v][7:0]});
            end else begin
                bus_write(VEC[v][16], VEC[v][15:8]);
            end
        end

        // R3 / R5 / R9: parallel view
        check("R3/R5/R9 cs_bits image", cs_bits_o, 32'h8000_0401);
        check("R9 pro flag set", {31'h0, pro_flag_o}, 32'h1);

        // R8: clock absent masks rate
        clk_present_i  = 1'b0;
        rate_code_i    = 2'b11;
        data_present_i = 1'b0;
        bus_read(1'b0, rd);
        check("R8 rate masked without clock", {24'h0, rd}, 32'h0);

        // R7: 32 kHz code with clock present
        clk_present_i = 1'b1;
        rate_code_i   = 2'b01;
        bus_read(1'b0, rd);
        check("R7 status 32k no data", {24'h0, rd}, 32'h03);
        data_present_i = 1'b1;
        rate_code_i    = 2'b11;
        bus_read(1'b0, rd);
        check("R7 status 48k with data", {24'h0, rd}, 32'h0F);

        // R1: mid-run reset, then write without a mode write
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 cs_bits after second reset", cs_bits_o, 32'h0);
        bus_write(1'b1, 8'h81);
        check("R1 write mode after reset", cs_bits_o, 32'h2);
        bus_write(1'b1, 8'hFF);   // bit31 via index with bits 6:5 set
        check("R4 high bits ignored at index 31", cs_bits_o, 32'h8000_0002);
        bus_read(1'b1, rd);
        check("R6 data read in write mode", {24'h0, rd}, 32'h80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule